// File: doc/BRIEF.md
# Two-Bank Mixed Edge/Level Interrupt Controller

This block gathers 64 raw interrupt lines into a single request to the processor. The sources are split into two banks of 32. Each bank has four word registers on a small memory-mapped bus: latched events, enables, an acknowledge strobe and the live line state. A fixed per-source mask makes a source level-sensitive or edge-sensitive.

Edge sources latch a bit on a rising edge, but only while they are enabled. Software clears that bit by writing a one to the acknowledge word. Level sources are never latched. They count as pending for as long as their synchronized line is high and they are enabled.

Firmware reads a status word that names the winning source. The winner is the highest-numbered pending source, and the upper bank beats the lower bank. Turning on an enable while the line is already high does not produce an event, so firmware must trigger a replay itself.

Top module: `banked_intc`

## Requirements
- R1: The window is 0x40 bytes, addressed by byte. The status word is at 0x00. The bank for sources 32..63 occupies 0x10..0x1C and the bank for sources 0..31 occupies 0x20..0x2C. Inside each bank the words are event (+0x0), enable (+0x4), acknowledge (+0x8) and level (+0xC). Bit n of a bank word belongs to source (bank base + n). Reads of the acknowledge word and of all other addresses return zero.
- R2: The level word returns the synchronized line state of all 32 sources in the bank. Sources 20..28 of the lower bank are level-sensitive. They are never latched into the event word and they are pending while their line is high and they are enabled.
- R3: An edge source sets its event bit one cycle after the two-stage synchronizer shows a rising edge, provided its enable bit is set at that moment.
- R4: Writing the acknowledge word clears every event bit that is written as one. Bits written as zero have no effect. When a set and a clear meet in the same cycle, the set wins.
- R5: Reading the enable word returns exactly the value last written to it.
- R6: Setting an enable bit while its line is already high does not set the event bit.
- R7: `irq_o` is, one cycle later, the OR of all pending sources, where pending means enabled and either latched or (for level sources) high.
- R8: The status word has bit 31 as a valid flag and bits 5:0 as the winning source number. The winner is the highest-numbered pending source, which puts the upper bank first. The status word reads zero when nothing is pending.
- R9: Synchronous reset clears all enables, events, synchronizer stages, `irq_o` and read data.
- R10: Writes to the event, level and status words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Raw interrupt lines, asynchronous |
| bus_addr | input | 6 | Byte address within the window |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the word addressed in the previous cycle |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a fresh edge. This requires knowing exactly when the edge leaves the synchronizer. The bench raises a line at a known falling edge, waits two clocks and then issues the acknowledge, so that the write and the set share one clock edge. Enabling a source whose line has been high for several cycles is driven the same way. A behavioural reference model runs alongside these directed cases and through a long random phase of line toggles and bus traffic, and it is compared against the outputs every cycle.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  // Address block (16 bytes each) used by a bank; block 0 is the status word.
  function automatic int bank_block(input int bank, input int num_banks);
    return num_banks - bank;
  endfunction
endpackage

// File: rtl/ictl_sync.sv
module ictl_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ictl_bank.sv
module ictl_bank #(
  parameter int         W        = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic         en_wr,
  input  logic         ack_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] ev_q, en_q, rise_ok, clr;

  assign rise_ok = rise_i & en_q & ~LVL_MASK;
  assign clr     = ack_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= (ev_q & ~clr) | rise_ok;
      if (en_wr) en_q <= wdata;
    end
  end

  assign ev_o   = ev_q;
  assign en_o   = en_q;
  assign pend_o = en_q & (ev_q | (lvl_i & LVL_MASK));

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> ((ev_q & $past(wdata & ~rise_ok)) == '0)); // R4
  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & ~$past(ev_q) & ~$past(en_q)) == '0)); // R6
  AST_LEVEL_NOT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & LVL_MASK) == '0)); // R2
endmodule

// File: rtl/ictl_prio.sv
module ictl_prio #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  timeunit 1ns; timeprecision 1ps;

  // Scan upward so the highest set bit is the one left standing.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int SYNC_STG  = 2,
  parameter int ADDR_W    = $clog2((NUM_BANKS + 1) * 16),
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_1ff0_0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        irq_o
);
  timeunit 1ns; timeprecision 1ps;
  import ictl_pkg::*;

  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int BLK_W   = ADDR_W - 4;

  logic [NUM_SRC-1:0] lvl_s, rise_s, ev_all, en_all, pend_all;
  logic [BLK_W-1:0]   blk;
  reg_sel_e           rsel;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [BANK_W-1:0]  rd_c, rdata_q;
  logic               irq_q;

  assign blk  = bus_addr[ADDR_W-1:4];
  assign rsel = reg_sel_e'(bus_addr[3:2]);

  ictl_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .raw_i(src_i), .sync_o(lvl_s), .rise_o(rise_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BLK = bank_block(b, NUM_BANKS);
    logic hit;
    assign hit = (int'(blk) == BLK) && bus_wr;

    ictl_bank #(.W(BANK_W), .LVL_MASK(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (lvl_s[b*BANK_W +: BANK_W]),
      .rise_i (rise_s[b*BANK_W +: BANK_W]),
      .en_wr  (hit && rsel == REG_ENABLE),
      .ack_wr (hit && rsel == REG_ACK),
      .wdata  (bus_wdata),
      .ev_o   (ev_all[b*BANK_W +: BANK_W]),
      .en_o   (en_all[b*BANK_W +: BANK_W]),
      .pend_o (pend_all[b*BANK_W +: BANK_W])
    );
  end

  ictl_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend_all), .valid_o(win_valid), .idx_o(win_idx)
  );

  always_comb begin
    rd_c = '0;
    if (int'(blk) == 0 && rsel == REG_EVENT)
      rd_c = {win_valid, {(BANK_W-1-IDX_W){1'b0}}, win_idx};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(blk) == NUM_BANKS - b) begin
        case (rsel)
          REG_EVENT:  rd_c = ev_all[b*BANK_W +: BANK_W];
          REG_ENABLE: rd_c = en_all[b*BANK_W +: BANK_W];
          REG_LEVEL:  rd_c = lvl_s[b*BANK_W +: BANK_W];
          default:    rd_c = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_c;
      irq_q   <= win_valid;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_IRQ_FOLLOWS_WINNER: assert property (@(posedge clk) disable iff (rst)
    irq_q == $past(win_valid)); // R7
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> pend_all[win_idx]); // R8
  AST_WIN_IS_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((pend_all >> win_idx) == NUM_SRC'(1))); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_q && en_all == '0 && ev_all == '0)); // R9
endmodule

// File: tb/banked_intc_bench.sv
module banked_intc_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [63:0] LVL = 64'h0000_0000_1ff0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  banked_intc u_banked_intc (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [63:0] m_s1, m_s2, m_s3, m_ev, m_en;
  logic        m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [5:0] a, input logic [63:0] pend);
    logic [31:0] r;
    r = '0;
    case (a[5:2])
      4'd0: begin
        for (int i = 63; i >= 0; i--)
          if (pend[i] && r == 0) r = 32'h8000_0000 | 32'(i);
      end
      4'd4:  r = m_ev[63:32];
      4'd5:  r = m_en[63:32];
      4'd7:  r = m_s2[63:32];
      4'd8:  r = m_ev[31:0];
      4'd9:  r = m_en[31:0];
      4'd11: r = m_s2[31:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    logic [63:0] rise, pend, ack, en_n;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ev = '0; m_en = '0;
      m_irq = 1'b0; m_rd = '0;
    end else begin
      rise = m_s2 & ~m_s3 & m_en & ~LVL;
      pend = m_en & (m_ev | (m_s2 & LVL));
      ack  = '0;
      en_n = m_en;
      if (wr) begin
        case (addr[5:2])
          4'd5:  en_n[63:32] = wdata;
          4'd6:  ack[63:32]  = wdata;
          4'd9:  en_n[31:0]  = wdata;
          4'd10: ack[31:0]   = wdata;
          default: ;
        endcase
      end
      m_rd  = model_read(addr, pend);
      m_irq = |pend;
      m_ev  = (m_ev & ~ack) | rise;
      m_en  = en_n;
      m_s3  = m_s2; m_s2 = m_s1; m_s1 = src;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic [5:0] a);
    case (a[5:2])
      4'd0:        return "R8 status";
      4'd5, 4'd9:  return "R5 enable";
      4'd4, 4'd8:  return "R3 event";
      4'd7, 4'd11: return "R2 level";
      default:     return "R1 unmapped";
    endcase
  endfunction

  // Continuous comparison, away from the active edge
  logic [5:0] addr_prev;
  always @(posedge clk) addr_prev <= addr;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
      check(tag_for(addr_prev), rdata, m_rd);
    end
  end

  task automatic op(input logic [5:0] a, input logic w, input logic [31:0] d);
    addr = a; wr = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(6'h3C, 1'b0, '0);
  endtask

  task automatic read_expect(input logic [5:0] a, input logic [31:0] exp, input string tag);
    op(a, 1'b0, '0);
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 irq after reset", {31'b0, irq}, 32'd0);
    read_expect(6'h24, 32'h0, "R9 enable lo after reset");
    read_expect(6'h14, 32'h0, "R9 enable hi after reset");
    read_expect(6'h00, 32'h0, "R9 status after reset");
    for (int a = 0; a < 64; a += 4) op(6'(a), 1'b0, '0); // R1 sweep

    // R5 enable readback
    op(6'h24, 1'b1, 32'hFFFF_FF5F);   // bit 5 and bit 7 off
    op(6'h14, 1'b1, 32'hA5A5_2F0F);
    read_expect(6'h24, 32'hFFFF_FF5F, "R5 lo readback");
    read_expect(6'h14, 32'hA5A5_2F0F, "R5 hi readback");
    op(6'h24, 1'b1, 32'hFFFF_FFDF);   // enable bit 7

    // R3 edge on source 3, then upper bank priority R8
    src[3] = 1'b1; idle(4);
    read_expect(6'h20, 32'h0000_0008, "R3 event lo bit3");
    src[40] = 1'b1; idle(4);
    read_expect(6'h00, 32'h8000_0028, "R8 upper bank wins");
    src[45] = 1'b1; idle(4);
    read_expect(6'h00, 32'h8000_002D, "R8 highest in bank");
    op(6'h18, 1'b1, 32'h0000_2000);   // R4 clear source 45 only
    read_expect(6'h10, 32'h0000_0100, "R4 ack clears one bit");
    op(6'h18, 1'b1, 32'h0);           // R4 zero write no effect
    read_expect(6'h10, 32'h0000_0100, "R4 zero ack no effect");

    // R2 level source 22
    op(6'h18, 1'b1, 32'hFFFF_FFFF);
    op(6'h28, 1'b1, 32'hFFFF_FFFF);
    src[22] = 1'b1; idle(3);
    read_expect(6'h00, 32'h8000_0016, "R2 level pending");
    src[22] = 1'b0; idle(3);
    read_expect(6'h00, 32'h0, "R2 level released");
    check("R7 irq low", {31'b0, irq}, 32'd0);

    // R6 enable while line already high
    src[5] = 1'b1; idle(5);
    op(6'h24, 1'b1, 32'hFFFF_FFFF); idle(3);
    read_expect(6'h20, 32'h0, "R6 no event on late enable");

    // R4 set wins against simultaneous acknowledge (source 7)
    src[7] = 1'b1;
    op(6'h3C, 1'b0, '0);
    op(6'h3C, 1'b0, '0);
    op(6'h28, 1'b1, 32'h0000_0080);
    read_expect(6'h20, 32'h0000_0080, "R4 set wins");

    // R10 writes to event, level and status ignored
    op(6'h20, 1'b1, 32'hFFFF_FFFF);
    op(6'h2C, 1'b1, 32'hFFFF_FFFF);
    op(6'h00, 1'b1, 32'hFFFF_FFFF);
    read_expect(6'h20, 32'h0000_0080, "R10 event write ignored");

    // Random phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      int pick;
      if ($urandom_range(0, 3) == 0) src[$urandom_range(0, 63)] ^= 1'b1;
      pick = $urandom_range(0, 9);
      a = 6'($urandom_range(0, 15) * 4);
      if (pick < 3) op(a, 1'b1, $urandom());
      else          op(a, 1'b0, '0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule